// File: doc/BRIEF.md
# Privileged interrupt arbiter with delegation

This block decides, every clock cycle, whether the hart should take an interrupt and which one. It combines a pending vector with an enable vector. It then splits the result into a machine-handled part and a supervisor-handled part, using a delegation vector. Each part is gated by the current privilege level and by the global interrupt-enable bit that belongs to its handler level. The lowest-numbered interrupt that survives the gating wins. It is reported as a cause word whose most significant bit marks it as an interrupt.

The pending, enable and delegation vectors are held in a small register file. Software writes it through a CSR port that carries a per-bit write mask. Only legal bits ever change. Pending bits driven by hardware are merged with the software-writable ones. The supervisor views of pending and enable are the machine vectors filtered by delegation.

Arbitration is combinational. Its result is registered in a two-state controller. State `ARB_IDLE` means no interrupt is offered. State `ARB_FIRE` means `take_o` is high and `cause_o` carries the winner. The transitions are:

- `IDLE_STAY`: no enabled interrupt, so the controller stays in `ARB_IDLE`.
- `IDLE_TO_FIRE`: an enabled interrupt appears, so the controller moves to `ARB_FIRE`.
- `FIRE_STAY`: an enabled interrupt remains, so the controller stays in `ARB_FIRE` and the cause follows the current winner.
- `FIRE_TO_IDLE`: the enabled set empties, so the controller returns to `ARB_IDLE`.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `take_o` is 0, `cause_o` is 0, and the software pending, enable and delegation registers all read as 0.
- R2: An interrupt takes part in arbitration only when its bit is set in both the pending vector and the enable vector.
- R3: A non-delegated interrupt is eligible when the privilege is below machine level, or when it is machine level and `mie_i` is 1.
- R4: A delegated interrupt is eligible when the privilege is user level, or when it is supervisor level and `sie_i` is 1. At machine level a delegated interrupt is never eligible.
- R5: When several interrupts are eligible, the one with the smallest bit index wins.
- R6: `take_o` and `cause_o` reflect the arbitration of the inputs and registers present at the previous rising clock edge. When taken, `cause_o[XLEN-1]` is 1, the low `$clog2(NIRQ)` bits hold the winning index, and all other bits are 0.
- R7: When no interrupt is eligible, `take_o` is 0 and `cause_o` is 0.
- R8: Only bits 1, 5, 9 and 12 of the delegation register (`csr_sel_i`=2) can be set. Writes to any other bit are ignored.
- R9: In the pending register (`csr_sel_i`=0), software can change only bits 1 and 5. A read returns those stored bits ORed with `hw_pend_i`.
- R10: Only bits 1, 3, 5, 7, 9 and 12 of the enable register (`csr_sel_i`=1) can be written.
- R11: The supervisor pending view (`csr_sel_i`=3) reads as pending AND delegation. The supervisor enable view (`csr_sel_i`=4) reads as enable AND delegation. Writes through either view change only delegated bits.
- R12: A CSR write changes only the bits whose `csr_wmask_i` bit is 1. With `csr_we_i` low, no register changes. A read with `csr_sel_i` 5 to 7 returns 0.
- R13: Privilege is encoded user=0, supervisor=1, machine=3. The value 2 behaves exactly like user level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_pend_i | input | NIRQ | Pending lines driven by hardware sources |
| priv_i | input | 2 | Current privilege level |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 3 | Register select: 0 pending, 1 enable, 2 delegation, 3 supervisor pending, 4 supervisor enable |
| csr_wdata_i | input | NIRQ | Write data |
| csr_wmask_i | input | NIRQ | Per-bit write mask |
| csr_rdata_o | output | NIRQ | Read data for the selected register |
| take_o | output | 1 | Interrupt is to be taken |
| cause_o | output | XLEN | Cause word of the winning interrupt |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that every input holds a known 0 or 1 value at each rising edge. With the default `NIRQ` of 16, the legal-bit positions all fall inside the vectors. The bench changes inputs only on falling edges and holds each value for at least one full cycle. It drives `priv_i` with all four codes, including the reserved code 2, and drives `csr_sel_i` only with codes 0 to 4 when writing.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        SEL_MPEND = 3'd0,
        SEL_MEN   = 3'd1,
        SEL_DELEG = 3'd2,
        SEL_SPEND = 3'd3,
        SEL_SEN   = 3'd4
    } csr_sel_e;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_FIRE = 1'b1
    } arb_state_e;

    // Interrupt bit positions (the arbitration priority depends on them)
    localparam int BIT_S_SOFT  = 1;
    localparam int BIT_M_SOFT  = 3;
    localparam int BIT_S_TIMER = 5;
    localparam int BIT_M_TIMER = 7;
    localparam int BIT_S_EXT   = 9;
    localparam int BIT_COPROC  = 12;

    localparam logic [63:0] DELEGABLE_64 = (64'd1 << BIT_S_SOFT) | (64'd1 << BIT_S_TIMER)
                                         | (64'd1 << BIT_S_EXT)  | (64'd1 << BIT_COPROC);
    localparam logic [63:0] SW_PEND_64   = (64'd1 << BIT_S_SOFT) | (64'd1 << BIT_S_TIMER);
    localparam logic [63:0] ENABLE_64    = DELEGABLE_64 | (64'd1 << BIT_M_SOFT)
                                         | (64'd1 << BIT_M_TIMER);

    // The reserved code 2 is handled as user level
    function automatic priv_e norm_priv(input logic [1:0] raw);
        if (raw == 2'd2) begin
            return PRIV_USER;
        end
        return priv_e'(raw);
    endfunction

endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
    import irq_arb_pkg::*;
#(
    parameter int NIRQ = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NIRQ-1:0] hw_pend_i,
    input  logic            we_i,
    input  logic [2:0]      sel_i,
    input  logic [NIRQ-1:0] wdata_i,
    input  logic [NIRQ-1:0] wmask_i,
    output logic [NIRQ-1:0] pend_o,
    output logic [NIRQ-1:0] en_o,
    output logic [NIRQ-1:0] deleg_o,
    output logic [NIRQ-1:0] rdata_o
);

    localparam logic [NIRQ-1:0] DELEG_OK = NIRQ'(DELEGABLE_64);
    localparam logic [NIRQ-1:0] PEND_OK  = NIRQ'(SW_PEND_64);
    localparam logic [NIRQ-1:0] EN_OK    = NIRQ'(ENABLE_64);

    logic [NIRQ-1:0] sw_pend_q, en_q, deleg_q;
    logic [NIRQ-1:0] pend_upd, en_upd, deleg_upd;

    // Per-register effective write mask: requested bits that are legal
    always_comb begin
        pend_upd  = '0;
        en_upd    = '0;
        deleg_upd = '0;
        if (we_i) begin
            case (csr_sel_e'(sel_i))
                SEL_MPEND: pend_upd  = wmask_i & PEND_OK;
                SEL_MEN:   en_upd    = wmask_i & EN_OK;
                SEL_DELEG: deleg_upd = wmask_i & DELEG_OK;
                SEL_SPEND: pend_upd  = wmask_i & PEND_OK & deleg_q;
                SEL_SEN:   en_upd    = wmask_i & EN_OK & deleg_q;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sw_pend_q <= '0;
            en_q      <= '0;
            deleg_q   <= '0;
        end else begin
            sw_pend_q <= (sw_pend_q & ~pend_upd)  | (wdata_i & pend_upd);
            en_q      <= (en_q      & ~en_upd)    | (wdata_i & en_upd);
            deleg_q   <= (deleg_q   & ~deleg_upd) | (wdata_i & deleg_upd);
        end
    end

    assign pend_o  = sw_pend_q | hw_pend_i;
    assign en_o    = en_q;
    assign deleg_o = deleg_q;

    always_comb begin
        case (csr_sel_e'(sel_i))
            SEL_MPEND: rdata_o = pend_o;
            SEL_MEN:   rdata_o = en_q;
            SEL_DELEG: rdata_o = deleg_q;
            SEL_SPEND: rdata_o = pend_o & deleg_q;
            SEL_SEN:   rdata_o = en_q & deleg_q;
            default:   rdata_o = '0;
        endcase
    end

    // R12: registers hold when no write is strobed
    assert_hold_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> ($stable(sw_pend_q) && $stable(en_q) && $stable(deleg_q)));

    // R8: delegation changes only through its own select
    assert_deleg_own_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i != 3'(SEL_DELEG)) |=> $stable(deleg_q));

    // R11: supervisor enable writes leave non-delegated bits alone
    assert_sup_en_scope_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == 3'(SEL_SEN)) |=> (((en_q ^ $past(en_q)) & ~$past(deleg_q)) == '0));

    // R11: supervisor pending writes leave non-delegated bits alone
    assert_sup_pend_scope_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == 3'(SEL_SPEND)) |=> (((sw_pend_q ^ $past(sw_pend_q)) & ~$past(deleg_q)) == '0));

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
    import irq_arb_pkg::*;
#(
    parameter int NIRQ  = 16,
    parameter int IDX_W = $clog2(NIRQ)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NIRQ-1:0]  pend_i,
    input  logic [NIRQ-1:0]  en_i,
    input  logic [NIRQ-1:0]  deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             mie_i,
    input  logic             sie_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    priv_e           cur_priv;
    logic            mach_ok, sup_ok;
    logic [NIRQ-1:0] live;
    logic [NIRQ-1:0] eligible;

    assign cur_priv = norm_priv(priv_i);
    assign mach_ok  = (cur_priv != PRIV_MACH) || mie_i;
    assign sup_ok   = (cur_priv == PRIV_USER) || ((cur_priv == PRIV_SUPER) && sie_i);
    assign live     = pend_i & en_i;

    // Per-bit gate: the handler level chosen by delegation picks the enable
    for (genvar b = 0; b < NIRQ; b++) begin : g_gate
        assign eligible[b] = live[b] & (deleg_i[b] ? sup_ok : mach_ok);
    end

    // Trailing-zero count: scanning downward leaves the smallest index
    always_comb begin
        idx_o = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |eligible;

    // R5: the reported winner is itself eligible
    assert_winner_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_o |-> eligible[idx_o]);

    // R5: nothing eligible below the winner
    assert_winner_lowest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_o |-> ((eligible & ((NIRQ'(1) << idx_o) - NIRQ'(1))) == '0));

    // R4: at machine level a delegated bit never wins
    assert_mach_no_deleg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i == 2'd3 && any_o) |-> !deleg_i[idx_o]);

    // R2: a winner is both pending and enabled
    assert_winner_pend_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_o |-> (pend_i[idx_o] && en_i[idx_o]));

endmodule

// File: rtl/irq_arb_fsm.sv
module irq_arb_fsm
    import irq_arb_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             take_o,
    output logic [XLEN-1:0]  cause_o
);

    arb_state_e      state_q, state_d;
    logic [XLEN-1:0] cause_d, cause_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: state_d = any_i ? ARB_FIRE : ARB_IDLE;  // IDLE_TO_FIRE / IDLE_STAY
            ARB_FIRE: state_d = any_i ? ARB_FIRE : ARB_IDLE;  // FIRE_STAY / FIRE_TO_IDLE
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: cause word formed for the state being entered
    always_comb begin
        cause_d = '0;
        if (state_d == ARB_FIRE) begin
            cause_d[XLEN-1]    = 1'b1;
            cause_d[IDX_W-1:0] = idx_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_d;
        end
    end

    assign take_o  = (state_q == ARB_FIRE);
    assign cause_o = cause_q;

    // R6: an eligible interrupt is offered on the next cycle
    assert_take_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_i |=> take_o);

    // R6: cause carries the interrupt flag and the previous winner
    assert_cause_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_i |=> (cause_o[XLEN-1] && cause_o[IDX_W-1:0] == $past(idx_i)
                   && cause_o[XLEN-2:IDX_W] == '0));

    // R7: with nothing eligible the outputs go quiet
    assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_i |=> (!take_o && cause_o == '0));

    // R7: no cause is shown without a take
    assert_no_stray_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_o |-> (cause_o == '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NIRQ = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NIRQ-1:0] hw_pend_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic            csr_we_i,
    input  logic [2:0]      csr_sel_i,
    input  logic [NIRQ-1:0] csr_wdata_i,
    input  logic [NIRQ-1:0] csr_wmask_i,
    output logic [NIRQ-1:0] csr_rdata_o,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);

    localparam int IDX_W = $clog2(NIRQ);

    logic [NIRQ-1:0]  pend, en, deleg;
    logic             any_win;
    logic [IDX_W-1:0] win_idx;

    irq_arb_regs #(.NIRQ(NIRQ)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hw_pend_i (hw_pend_i),
        .we_i      (csr_we_i),
        .sel_i     (csr_sel_i),
        .wdata_i   (csr_wdata_i),
        .wmask_i   (csr_wmask_i),
        .pend_o    (pend),
        .en_o      (en),
        .deleg_o   (deleg),
        .rdata_o   (csr_rdata_o)
    );

    irq_arb_select #(.NIRQ(NIRQ), .IDX_W(IDX_W)) u_select (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend),
        .en_i    (en),
        .deleg_i (deleg),
        .priv_i  (priv_i),
        .mie_i   (mie_i),
        .sie_i   (sie_i),
        .any_o   (any_win),
        .idx_o   (win_idx)
    );

    irq_arb_fsm #(.XLEN(XLEN), .IDX_W(IDX_W)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .any_i   (any_win),
        .idx_i   (win_idx),
        .take_o  (take_o),
        .cause_o (cause_o)
    );

endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;

    localparam int XLEN = 32;
    localparam int NIRQ = 16;
    localparam logic [15:0] DLG_OK  = 16'h1222;  // bits 1,5,9,12
    localparam logic [15:0] PEND_OK = 16'h0022;  // bits 1,5
    localparam logic [15:0] EN_OK   = 16'h12AA;  // bits 1,3,5,7,9,12

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] hw_pend = '0;
    logic [1:0]      priv = 2'd3;
    logic            mie = 1'b0, sie = 1'b0;
    logic            we = 1'b0;
    logic [2:0]      sel = 3'd0;
    logic [NIRQ-1:0] wdata = '0, wmask = '0;
    logic [NIRQ-1:0] rdata;
    logic            take;
    logic [XLEN-1:0] cause;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t q[$];

    logic [15:0] m_sw = '0, m_en = '0, m_dlg = '0;

    always #2.5 clk = ~clk;

    irq_arbiter #(.XLEN(XLEN), .NIRQ(NIRQ)) uut (
        .clk_i(clk), .rst_ni(rst_n), .hw_pend_i(hw_pend), .priv_i(priv),
        .mie_i(mie), .sie_i(sie), .csr_we_i(we), .csr_sel_i(sel),
        .csr_wdata_i(wdata), .csr_wmask_i(wmask), .csr_rdata_o(rdata),
        .take_o(take), .cause_o(cause)
    );

    function automatic logic [31:0] model_cause();
        logic [15:0] live, elig;
        logic [1:0]  p;
        bit          mon, son;
        live = (m_sw | hw_pend) & m_en;
        p    = (priv == 2'd2) ? 2'd0 : priv;
        mon  = (p != 2'd3) || mie;
        son  = (p == 2'd0) || (p == 2'd1 && sie);
        elig = (live & ~m_dlg & {16{mon}}) | (live & m_dlg & {16{son}});
        for (int i = 0; i < 16; i++) begin
            if (elig[i]) return 32'h8000_0000 | 32'(i);
        end
        return 32'h0;
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] s);
        logic [15:0] p;
        p = m_sw | hw_pend;
        case (s)
            3'd0: return 32'(p);
            3'd1: return 32'(m_en);
            3'd2: return 32'(m_dlg);
            3'd3: return 32'(p & m_dlg);
            3'd4: return 32'(m_en & m_dlg);
            default: return 32'h0;
        endcase
    endfunction

    task automatic csr_write(input logic [2:0] s, input logic [15:0] d, input logic [15:0] m);
        logic [15:0] mp, me, md;
        @(negedge clk);
        sel = s; wdata = d; wmask = m; we = 1'b1;
        mp = '0; me = '0; md = '0;
        case (s)
            3'd0: mp = m & PEND_OK;
            3'd1: me = m & EN_OK;
            3'd2: md = m & DLG_OK;
            3'd3: mp = m & PEND_OK & m_dlg;
            3'd4: me = m & EN_OK & m_dlg;
            default: ;
        endcase
        m_sw  = (m_sw & ~mp) | (d & mp);
        m_en  = (m_en & ~me) | (d & me);
        m_dlg = (m_dlg & ~md) | (d & md);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic expect_read(input logic [2:0] s, input string req);
        item_t it;
        @(negedge clk);
        sel = s;
        it.is_read = 1'b1; it.exp = model_read(s); it.req = req;
        q.push_back(it);
    endtask

    task automatic expect_arb(input logic [15:0] hw, input logic [1:0] p,
                              input logic m_ie, input logic s_ie, input string req);
        item_t it;
        @(negedge clk);
        hw_pend = hw; priv = p; mie = m_ie; sie = s_ie;
        @(negedge clk);
        it.is_read = 1'b0; it.exp = model_cause(); it.req = req;
        q.push_back(it);
    endtask

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                n_checks++;
                if (it.is_read) begin
                    act = 32'(rdata);
                    if (act !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s read: actual %h expected %h", it.req, act, it.exp);
                    end
                end else begin
                    if (cause !== it.exp || take !== (it.exp != 0)) begin
                        n_fail++;
                        $display("FAIL %s arb: actual take=%b cause=%h expected take=%b cause=%h",
                                 it.req, take, cause, (it.exp != 0), it.exp);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_arb(16'h0, 2'd3, 1'b1, 1'b1, "R1");
        expect_read(3'd0, "R1");
        expect_read(3'd1, "R1");
        expect_read(3'd2, "R1");
        // R8: only delegable bits stick
        csr_write(3'd2, 16'hFFFF, 16'hFFFF);
        expect_read(3'd2, "R8");
        // R12: per-bit mask on enable
        csr_write(3'd1, 16'hFFFF, 16'h00F0);
        expect_read(3'd1, "R12");
        // R10: only legal enable bits
        csr_write(3'd1, 16'hFFFF, 16'hFFFF);
        expect_read(3'd1, "R10");
        // R9: only bits 1,5 writable; hardware lines ORed into the read
        csr_write(3'd0, 16'hFFFF, 16'hFFFF);
        expect_arb(16'h0100, 2'd3, 1'b0, 1'b0, "R9");
        expect_read(3'd0, "R9");
        // R11: supervisor views and scoped writes
        csr_write(3'd2, 16'h0002, 16'hFFFF);
        expect_read(3'd3, "R11");
        expect_read(3'd4, "R11");
        csr_write(3'd4, 16'h0000, 16'hFFFF);
        expect_read(3'd1, "R11");
        csr_write(3'd3, 16'h0000, 16'hFFFF);
        expect_read(3'd0, "R11");
        // R12: unused select reads zero, no write without strobe
        expect_read(3'd6, "R12");
        // Arbitration setup: enable all, delegate 1,5,9, pend bit 5 by software
        csr_write(3'd1, 16'hFFFF, 16'hFFFF);
        csr_write(3'd2, 16'h0222, 16'hFFFF);
        csr_write(3'd0, 16'h0020, 16'hFFFF);
        expect_arb(16'h0000, 2'd3, 1'b1, 1'b1, "R4");  // delegated blocked at M
        expect_arb(16'h0000, 2'd1, 1'b0, 1'b0, "R4");  // S with sie=0
        expect_arb(16'h0000, 2'd1, 1'b0, 1'b1, "R6");  // S with sie=1 -> cause 5
        expect_arb(16'h0000, 2'd0, 1'b0, 1'b0, "R4");  // U always
        expect_arb(16'h0088, 2'd3, 1'b0, 1'b1, "R3");  // M, mie=0 -> none
        expect_arb(16'h0088, 2'd3, 1'b1, 1'b0, "R5");  // M, mie=1 -> 3
        expect_arb(16'h0088, 2'd1, 1'b0, 1'b0, "R3");  // below M -> 3
        expect_arb(16'h0080, 2'd2, 1'b0, 1'b0, "R13"); // code 2 as U -> 5
        expect_arb(16'h1200, 2'd0, 1'b0, 1'b0, "R5");  // 5 vs 9 vs 12
        csr_write(3'd0, 16'h0000, 16'hFFFF);
        expect_arb(16'h1200, 2'd3, 1'b1, 1'b0, "R5");  // M: 12 only
        // R2: pending but not enabled
        csr_write(3'd1, 16'h0000, 16'h1000);
        expect_arb(16'h1000, 2'd3, 1'b1, 1'b1, "R2");
        expect_arb(16'h0400, 2'd0, 1'b1, 1'b1, "R2");
        // R7: outputs return to quiet
        expect_arb(16'h0000, 2'd3, 1'b1, 1'b1, "R7");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule